// File: doc/BRIEF.md
# Dependency-Aware Unit Speed Controller

This block sits beside one functional unit of an out-of-order core whose units run in separate clock domains. Each cycle it looks at two counts: how many entries in the unit's issue queue are ready to issue, and how many instructions in other units wait directly on a result from this unit. From these it chooses between a fast and a slow operating point. A queue full of blocked instructions therefore does not keep the unit fast. Only ready work, or other units waiting on this one, does.

Each cycle the block decides whether a "slow-down event" occurred. It counts these events in a saturating counter and compares the total against a programmable interval. Time is split into fixed windows of `WIN_CYC` cycles. At the end of each window, and on every change of speed, the counter and the window restart. In the fast state a burst of starved cycles moves the unit to slow at once. The slow state is left only at a window end, and only if that window held fewer events than the interval. This gives the decision hysteresis. The output is one speed bit and a one-cycle pulse on each change. Voltage and frequency actuation happen elsewhere.

Top module: `dsc_speed_ctrl`

## Requirements
- R1: In reset and in the first cycle after it, `speed_hi_o` is 1 (the fast state) and `change_o` is 0. The event counter and the window position both start at zero.
- R2: In the fast state an event is counted on each cycle where `ind_cnt_i < ind_thr_i`. The dependency count has no effect in this state.
- R3: In the fast state, the block moves to slow on the clock edge where the event count, including that cycle's event, exceeds `interval_i`. A count equal to `interval_i` keeps it fast.
- R4: In the slow state an event is counted on each cycle where `ind_cnt_i < ind_thr_i` or `dep_cnt_i > dep_thr_i`.
- R5: In the slow state the block compares the count, including that cycle's event, with `interval_i` on the last cycle of each `WIN_CYC`-cycle window. If the count is below `interval_i` it returns to fast. If the count is equal or greater it stays slow.
- R6: The slow state is never left on a cycle that is not the last cycle of a window.
- R7: The event counter saturates at 2^EVT_W-1 and never wraps to a smaller nonzero value or to zero on an increment.
- R8: `speed_hi_o` is 1 for fast and 0 for slow. `change_o` is 1 for exactly the one cycle in which `speed_hi_o` has just taken a new value.
- R9: The event counter and the window position restart at zero at the end of every window and on every change of speed. A new window therefore starts with each state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ind_cnt_i | input | CNT_W | Dependency-free entries in the issue queue |
| dep_cnt_i | input | CNT_W | Direct dependencies other units hold on this unit |
| ind_thr_i | input | CNT_W | Ready-entry threshold |
| dep_thr_i | input | CNT_W | Dependency-pressure threshold |
| interval_i | input | EVT_W | Event limit compared with the event counter |
| speed_hi_o | output | 1 | 1 = fast state, 0 = slow state |
| change_o | output | 1 | One-cycle pulse when the speed changes |

## Verification
The hardest case to reach is the saturation corner. The counter must fill up in the slow state across a whole window. If it wrapped, it would make the end-of-window decision on a small count. The slow state can only be entered with a small interval, because the counter cannot exceed its own maximum in the fast state. So the stimulus first drives the unit to slow with a small interval. It then raises `interval_i` to the counter maximum and holds a slow-down condition for a full window. A wrap would wrongly return the unit to fast. The bench also places event bursts on both sides of a window boundary, which shows that the count restarts there.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic {
        SPD_LOW  = 1'b0,
        SPD_HIGH = 1'b1
    } spd_e;

    typedef struct packed {
        spd_e state;
        logic change;
    } ctrl_s;

endpackage

// File: rtl/dsc_event_detect.sv
module dsc_event_detect #(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] ind_cnt_i,
    input  logic [CNT_W-1:0] dep_cnt_i,
    input  logic [CNT_W-1:0] ind_thr_i,
    input  logic [CNT_W-1:0] dep_thr_i,
    output logic             starved_o,
    output logic             pressed_o
);

    // Too little ready work for the unit.
    always_comb starved_o = (ind_cnt_i < ind_thr_i);

    // Other units depend heavily on this unit's results.
    always_comb pressed_o = (dep_cnt_i > dep_thr_i);

endmodule

// File: rtl/dsc_window_timer.sv
module dsc_window_timer #(
    parameter int WIN_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic last_o
);

    localparam int WIN_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [WIN_W-1:0] LAST_POS = WIN_W'(WIN_CYC - 1);

    logic [WIN_W-1:0] pos_d, pos_q;

    always_comb begin
        last_o = (pos_q == LAST_POS);
        pos_d  = pos_q + WIN_W'(1);
        if (restart_i || last_o) begin
            pos_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

endmodule

// File: rtl/dsc_event_counter.sv
module dsc_event_counter #(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clear_i,
    output logic [EVT_W-1:0] cnt_o,
    output logic [EVT_W-1:0] nxt_o
);

    localparam logic [EVT_W-1:0] CNT_MAX = {EVT_W{1'b1}};

    logic [EVT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        // Count including this cycle's event, held at the top value.
        if (cnt_q == CNT_MAX) begin
            nxt_o = cnt_q;
        end else begin
            nxt_o = cnt_q + EVT_W'(inc_i);
        end
        cnt_d = clear_i ? '0 : nxt_o;
        cnt_o = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/dsc_speed_ctrl.sv
module dsc_speed_ctrl
    import dsc_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int EVT_W   = 4,
    parameter int WIN_CYC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ind_cnt_i,
    input  logic [CNT_W-1:0] dep_cnt_i,
    input  logic [CNT_W-1:0] ind_thr_i,
    input  logic [CNT_W-1:0] dep_thr_i,
    input  logic [EVT_W-1:0] interval_i,
    output logic             speed_hi_o,
    output logic             change_o
);

    ctrl_s ctrl_d, ctrl_q;

    logic             starved, pressed;
    logic             evt_hit;
    logic             restart;
    logic             win_last;
    logic             evt_clear;
    logic [EVT_W-1:0] evt_q, evt_nx;

    dsc_event_detect #(.CNT_W(CNT_W)) detect_i (
        .ind_cnt_i (ind_cnt_i),
        .dep_cnt_i (dep_cnt_i),
        .ind_thr_i (ind_thr_i),
        .dep_thr_i (dep_thr_i),
        .starved_o (starved),
        .pressed_o (pressed)
    );

    dsc_window_timer #(.WIN_CYC(WIN_CYC)) window_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .last_o    (win_last)
    );

    dsc_event_counter #(.EVT_W(EVT_W)) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (evt_hit),
        .clear_i (evt_clear),
        .cnt_o   (evt_q),
        .nxt_o   (evt_nx)
    );

    always_comb begin
        ctrl_d        = ctrl_q;
        ctrl_d.change = 1'b0;
        restart       = 1'b0;

        // Dependency pressure counts only while slow.
        if (ctrl_q.state == SPD_HIGH) begin
            evt_hit = starved;
        end else begin
            evt_hit = starved | pressed;
        end

        unique case (ctrl_q.state)
            SPD_HIGH: begin
                if (evt_nx > interval_i) begin
                    ctrl_d.state  = SPD_LOW;
                    ctrl_d.change = 1'b1;
                    restart       = 1'b1;
                end
            end
            SPD_LOW: begin
                if (win_last && (evt_nx < interval_i)) begin
                    ctrl_d.state  = SPD_HIGH;
                    ctrl_d.change = 1'b1;
                    restart       = 1'b1;
                end
            end
            default: ctrl_d.state = SPD_HIGH;
        endcase

        evt_clear = restart | win_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: SPD_HIGH, change: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign speed_hi_o = (ctrl_q.state == SPD_HIGH);
    assign change_o   = ctrl_q.change;

endmodule

// File: rtl/dsc_speed_ctrl_chk.sv
module dsc_speed_ctrl_chk #(
    parameter int CNT_W = 6,
    parameter int EVT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] ind_cnt_i,
    input logic [CNT_W-1:0] ind_thr_i,
    input logic             speed_hi_o,
    input logic             change_o,
    input logic             win_last,
    input logic [EVT_W-1:0] evt_q
);

    // R1: leaving reset always lands in the fast state with no pulse
    a_r1_reset_fast: assert property (@(posedge clk)
        !rst_n |=> (speed_hi_o && !change_o));

    // R8: the pulse marks exactly the cycles where the speed bit moved
    a_r8_change_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        change_o == (speed_hi_o != $past(speed_hi_o)));

    // R2: fast state without a starved cycle cannot drop to slow
    a_r2_fast_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_hi_o && !(ind_cnt_i < ind_thr_i)) |=> speed_hi_o);

    // R6: slow state is left only on the last cycle of a window
    a_r6_window_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (!speed_hi_o && !win_last) |=> !speed_hi_o);

    // R7: a nonzero count is the previous count or one more, never a wrap
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q != '0) |-> ((evt_q == $past(evt_q)) ||
                           (evt_q == $past(evt_q) + EVT_W'(1))));

endmodule

bind dsc_speed_ctrl dsc_speed_ctrl_chk #(
    .CNT_W (CNT_W),
    .EVT_W (EVT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ind_cnt_i  (ind_cnt_i),
    .ind_thr_i  (ind_thr_i),
    .speed_hi_o (speed_hi_o),
    .change_o   (change_o),
    .win_last   (win_last),
    .evt_q      (evt_q)
);

// File: tb/dsc_speed_ctrl_tb_top.sv
module dsc_speed_ctrl_tb_top;

    localparam int CNT_W = 6;
    localparam int EVT_W = 4;
    localparam int WIN   = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] ind_cnt_i = '0;
    logic [CNT_W-1:0] dep_cnt_i = '0;
    logic [CNT_W-1:0] ind_thr_i = 6'd4;
    logic [CNT_W-1:0] dep_thr_i = 6'd3;
    logic [EVT_W-1:0] interval_i = 4'd5;
    logic             speed_hi_o;
    logic             change_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dsc_speed_ctrl #(.CNT_W(CNT_W), .EVT_W(EVT_W), .WIN_CYC(WIN)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ind_cnt_i  (ind_cnt_i),
        .dep_cnt_i  (dep_cnt_i),
        .ind_thr_i  (ind_thr_i),
        .dep_thr_i  (dep_thr_i),
        .interval_i (interval_i),
        .speed_hi_o (speed_hi_o),
        .change_o   (change_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Quiet inputs: ready work above threshold, no dependency pressure.
    task automatic idle_inputs();
        ind_cnt_i = 6'd10;
        dep_cnt_i = 6'd0;
    endtask

    task automatic do_reset(input logic [EVT_W-1:0] ival);
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        interval_i = ival;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(4'd5);
        check("R1 speed after reset", speed_hi_o, 1'b1);
        check("R1 change after reset", change_o, 1'b0);
        tick(1);
        check("R1 speed first cycle", speed_hi_o, 1'b1);
    endtask

    task automatic t_fast_to_slow();
        do_reset(4'd5);
        ind_cnt_i = 6'd1;
        tick(5);
        check("R3 five events equal to interval stay fast", speed_hi_o, 1'b1);
        tick(1);
        check("R3 sixth event drops to slow", speed_hi_o, 1'b0);
        check("R8 change pulse on drop", change_o, 1'b1);
        idle_inputs();
        tick(1);
        check("R8 change pulse lasts one cycle", change_o, 1'b0);
    endtask

    task automatic t_fast_ignores_dep();
        do_reset(4'd5);
        dep_cnt_i = 6'd40;
        tick(40);
        check("R2 dependency pressure ignored when fast", speed_hi_o, 1'b1);
        check("R2 no change pulse", change_o, 1'b0);
    endtask

    task automatic t_window_clears_fast();
        do_reset(4'd5);
        tick(27);
        ind_cnt_i = 6'd0;
        tick(10);
        idle_inputs();
        tick(3);
        check("R9 count clears at window end in fast state", speed_hi_o, 1'b1);
    endtask

    task automatic t_slow_to_fast();
        do_reset(4'd5);
        ind_cnt_i = 6'd1;
        tick(6);
        idle_inputs();
        check("R3 in slow state", speed_hi_o, 1'b0);
        tick(31);
        check("R6 slow held until window end", speed_hi_o, 1'b0);
        check("R9 window restarted on change", speed_hi_o, 1'b0);
        tick(1);
        check("R5 return to fast at window end", speed_hi_o, 1'b1);
        check("R8 change pulse on rise", change_o, 1'b1);
    endtask

    task automatic t_slow_equal_stays();
        do_reset(4'd5);
        ind_cnt_i = 6'd1;
        tick(6);
        idle_inputs();
        // Five dependency-pressure events in the first slow window.
        dep_cnt_i = 6'd9;
        tick(5);
        dep_cnt_i = 6'd0;
        tick(27);
        check("R4 R5 count equal to interval keeps slow", speed_hi_o, 1'b0);
        tick(31);
        check("R6 still slow inside second window", speed_hi_o, 1'b0);
        tick(1);
        check("R5 quiet window returns to fast", speed_hi_o, 1'b1);
    endtask

    task automatic t_slow_dep_holds();
        do_reset(4'd5);
        ind_cnt_i = 6'd1;
        tick(6);
        ind_cnt_i = 6'd10;
        dep_cnt_i = 6'd20;
        tick(70);
        check("R4 dependency pressure keeps slow", speed_hi_o, 1'b0);
        idle_inputs();
    endtask

    task automatic t_saturate();
        do_reset(4'd5);
        ind_cnt_i = 6'd1;
        tick(6);
        check("R7 entered slow", speed_hi_o, 1'b0);
        interval_i = 4'd15;
        tick(32);
        check("R7 saturated count keeps slow at window end", speed_hi_o, 1'b0);
        idle_inputs();
    endtask

    initial begin
        t_reset();
        t_fast_to_slow();
        t_fast_ignores_dep();
        t_window_clears_fast();
        t_slow_to_fast();
        t_slow_equal_stays();
        t_slow_dep_holds();
        t_saturate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule